// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds six 8-bit configuration registers for a differential clock fan-out stage. A host uses the bus to set the clock buffer's operating modes and per-output enable and stop masks at system start. The current register contents are driven straight out as parallel buses to the clock control logic.

The block samples SCL and SDA with a fast system clock and passes each line through a synchroniser and a two-flop agreement filter. START and STOP are recognised as SDA edges while SCL is high. Bit 7 of the command code picks the access type. A single-byte access addresses one register directly. A block access carries a byte count and always begins at register 0. The slave acknowledges by pulling SDA low through an open-drain enable.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1101110, which is 0xDC as a write byte and 0xDD as a read byte. For any other address it leaves SDA released, and the data bytes that follow change no register.
- R2: A write whose command byte has bit 7 = 1 stores the next data byte, sent MSB first, in the register at offset command[6:0], and acknowledges every byte.
- R3: A read whose command byte has bit 7 = 1 is sent as address+W, command, repeated START, address+R. The slave then returns the register at offset command[6:0], MSB first.
- R4: A write whose command byte is 0x00 takes a byte count as its next byte. The data bytes after it go to registers 0, 1, 2 and onward in ascending order.
- R5: A STOP after any complete data byte of a block write ends the transfer. The bytes already received are kept, and the registers beyond them keep their values.
- R6: A block read (command 0x00, repeated START, address+R) returns a byte count of 6 and then registers 0 to 5 in order, for as long as the master acknowledges.
- R7: After reset the register values are 0x07, 0xFF, 0x00, 0x00, 0x08 and 0x00 for registers 0 to 5. The outputs map as follows: register 0 to mode_o, register 1 to out_en_o, register 2 to stop_mask_o, register 3 to spare3_o, register 4 to ident_o and register 5 to spare5_o.
- R8: Register 4 is read-only. Offsets above 5 are acknowledged, their write data is discarded, and they read back as 0x00.
- R9: A STOP in the middle of a byte aborts the transfer and releases SDA, and the next transaction works normally. The slave never starts pulling SDA low while SCL is high.
- R10: After the master answers a read byte with NACK, the slave releases SDA before the next SCL rise and drives nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| mode_o | output | 8 | Register 0: drive modes, bandwidth, PLL/bypass, divide-by-two (active low) |
| out_en_o | output | 8 | Register 1: per-output enables |
| stop_mask_o | output | 8 | Register 2: per-output stoppable mask |
| spare3_o | output | 8 | Register 3: spare |
| ident_o | output | 8 | Register 4: revision and vendor code, read-only |
| spare5_o | output | 8 | Register 5: spare |

## Verification
The embedded properties check four things on every cycle. A detected STOP releases SDA. The slave's pull-down never begins while filtered SCL is high. A master NACK on a read byte returns the slave to idle with SDA released. Each write strobe to a writable register leaves exactly that value in it. Only the bench's bus scenarios can show the rest: address filtering, byte and block addressing, byte-count handling, keeping a partial block write, the block-read count and order, read-only and out-of-range offsets, and recovery after a STOP in the middle of a byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int          NUM_REGS    = 6;
  localparam int          DW          = 8;
  localparam int          OFS_W       = 7;
  localparam int          RO_IDX      = 4;
  localparam logic [6:0]  DEV_ADDR    = 7'h6E;
  localparam logic [7:0]  BLK_COUNT   = 8'(NUM_REGS);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} bus_state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_COUNT, PH_DATA} rx_phase_e;

  function automatic logic [DW-1:0] reg_rst(int idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      4:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_sync_q, sda_sync_q;
  logic       scl_f_q, sda_f_q, scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_f_q    <= 1'b1;
      sda_f_q    <= 1'b1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[1:0], scl_i};
      sda_sync_q <= {sda_sync_q[1:0], sda_i};
      // accept a level only once two stages agree
      if (scl_sync_q[1] == scl_sync_q[2]) scl_f_q <= scl_sync_q[2];
      if (sda_sync_q[1] == sda_sync_q[2]) sda_f_q <= sda_sync_q[2];
      scl_d_q <= scl_f_q;
      sda_d_q <= sda_f_q;
    end
  end

  assign scl_o      = scl_f_q;
  assign sda_o      = sda_f_q;
  assign scl_rise_o = scl_f_q & ~scl_d_q;
  assign scl_fall_o = ~scl_f_q & scl_d_q;
  assign start_o    = scl_f_q & scl_d_q & sda_d_q & ~sda_f_q;
  assign stop_o     = scl_f_q & scl_d_q & ~sda_d_q & sda_f_q;
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = DEV_ADDR,
  parameter int         AW         = OFS_W,
  parameter int         W          = DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [W-1:0]  rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [W-1:0]  wr_data_o,
  output logic          sda_oe_o
);
  localparam int CW = $clog2(W) + 1;

  bus_state_e    state_q;
  rx_phase_e     phase_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic [AW-1:0] ptr_q, ptr_inc;
  logic          rw_q, blk_q, mack_q, oe_q;

  assign ptr_inc = (ptr_q == '1) ? ptr_q : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      cnt_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      blk_q     <= 1'b0;
      mack_q    <= 1'b1;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_RX;
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != CW'(W)) begin
              sh_q  <= {sh_q[W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CW'(W)) begin
              cnt_q <= '0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (sh_q[W-1:1] == SLAVE_ADDR) begin
                    rw_q    <= sh_q[0];
                    oe_q    <= 1'b1;
                    state_q <= ST_RX_ACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                PH_CMD: begin
                  blk_q   <= ~sh_q[W-1];
                  ptr_q   <= sh_q[W-1] ? sh_q[AW-1:0] : '0;
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
                PH_COUNT: begin
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_q;
                  wr_data_o <= sh_q;
                  ptr_q     <= ptr_inc;
                  oe_q      <= 1'b1;
                  state_q   <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              if (phase_q == PH_ADDR && rw_q) begin
                state_q <= ST_TX;
                cnt_q   <= '0;
                if (blk_q) begin
                  sh_q <= BLK_COUNT;
                  oe_q <= ~BLK_COUNT[W-1];
                end else begin
                  sh_q  <= rd_data_i;
                  oe_q  <= ~rd_data_i[W-1];
                  ptr_q <= ptr_inc;
                end
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
                unique case (phase_q)
                  PH_ADDR: phase_q <= PH_CMD;
                  PH_CMD:  phase_q <= blk_q ? PH_COUNT : PH_DATA;
                  default: phase_q <= PH_DATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == CW'(W - 1)) begin
                state_q <= ST_TX_ACK;
                oe_q    <= 1'b0;
              end else begin
                sh_q  <= {sh_q[W-2:0], 1'b0};
                oe_q  <= ~sh_q[W-2];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              mack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (!mack_q) begin
                state_q <= ST_TX;
                cnt_q   <= '0;
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[W-1];
                ptr_q   <= ptr_inc;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign sda_oe_o  = oe_q;

  p_release_on_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  p_pull_only_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  p_nack_releases_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_ACK && scl_fall_i && mack_q && !start_i && !stop_i)
      |=> (state_q == ST_IDLE && !sda_oe_o));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import smb_cfg_pkg::*;
#(
  parameter int N     = NUM_REGS,
  parameter int W     = DW,
  parameter int AW    = OFS_W,
  parameter int RO    = RO_IDX
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic [N*W-1:0] regs_o
);
  localparam int IW = $clog2(N);

  logic [W-1:0] q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == RO) begin : g_ro
      assign q[g] = reg_rst(g);
    end else begin : g_rw
      logic [W-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                r_q <= reg_rst(g);
        else if (wr_en_i && wr_addr_i == AW'(g))    r_q <= wr_data_i;
      end
      assign q[g] = r_q;

      p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == AW'(g)) |=> r_q == $past(wr_data_i));
    end
    assign regs_o[g*W +: W] = q[g];
  end

  assign rd_data_o = (rd_addr_i < AW'(N)) ? q[rd_addr_i[IW-1:0]] : '0;
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = DEV_ADDR
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_oe_o,
  output logic [7:0]   mode_o,
  output logic [7:0]   out_en_o,
  output logic [7:0]   stop_mask_o,
  output logic [7:0]   spare3_o,
  output logic [7:0]   ident_o,
  output logic [7:0]   spare5_o
);
  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [OFS_W-1:0]  wr_addr, rd_addr;
  logic [DW-1:0]     wr_data, rd_data;
  logic [NUM_REGS*DW-1:0] regs;

  smb_line_filter u_filt (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_f), .sda_o(sda_f), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_slave_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .AW(OFS_W), .W(DW)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o
  );

  cfg_regfile #(.N(NUM_REGS), .W(DW), .AW(OFS_W), .RO(RO_IDX)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .regs_o(regs)
  );

  assign mode_o      = regs[0*DW +: DW];
  assign out_en_o    = regs[1*DW +: DW];
  assign stop_mask_o = regs[2*DW +: DW];
  assign spare3_o    = regs[3*DW +: DW];
  assign ident_o     = regs[4*DW +: DW];
  assign spare5_o    = regs[5*DW +: DW];
endmodule

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;
  localparam int Q = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [7:0] mode, out_en, stop_mask, spare3, ident, spare5;
  assign sda_bus = ~(m_low | sda_oe);

  smb_cfg_slave dut (
    .clk_i(clk), .rst_ni, .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .mode_o(mode), .out_en_o(out_en), .stop_mask_o(stop_mask),
    .spare3_o(spare3), .ident_o(ident), .spare5_o(spare5)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [6] = '{8'h07, 8'hFF, 8'h00, 8'h00, 8'h08, 8'h00};
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] act_q [$];

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hq;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic b_start;
    m_low = 0; scl = 1; hq; m_low = 1; hq; scl = 0; hq;
  endtask
  task automatic b_rstart;
    m_low = 0; hq; scl = 1; hq; m_low = 1; hq; scl = 0; hq;
  endtask
  task automatic b_stop;
    m_low = 1; hq; scl = 1; hq; m_low = 0; hq;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hq; scl = 1; hq; scl = 0;
    end
    m_low = 0; hq; scl = 1; hq; ack = ~sda_bus; scl = 0; hq;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      hq; scl = 1; hq; b[i] = sda_bus; scl = 0;
    end
    m_low = give_ack; hq; scl = 1; hq; scl = 0; hq; m_low = 0;
  endtask

  task automatic check_outs(string tag);
    chk({tag, " mode_o"}, mode, model[0]);
    chk({tag, " out_en_o"}, out_en, model[1]);
    chk({tag, " stop_mask_o"}, stop_mask, model[2]);
    chk({tag, " spare3_o"}, spare3, model[3]);
    chk({tag, " ident_o"}, ident, model[4]);
    chk({tag, " spare5_o"}, spare5, model[5]);
  endtask

  task automatic byte_write(input logic [6:0] ofs, input logic [7:0] d, input string tag);
    logic a;
    b_start;
    wr_byte(8'hDC, a); chk({tag, " addr ack"}, 8'(a), 8'h01);
    wr_byte({1'b1, ofs}, a); chk({tag, " cmd ack"}, 8'(a), 8'h01);
    wr_byte(d, a); chk({tag, " data ack"}, 8'(a), 8'h01);
    b_stop;
    if (ofs < 7'd6 && ofs != 7'd4) model[ofs[2:0]] = d;
  endtask

  task automatic byte_read(input logic [6:0] ofs, input logic [7:0] exp, input string tag);
    logic a;
    logic [7:0] b;
    exp_q.push_back(exp); tag_q.push_back(tag);
    b_start;
    wr_byte(8'hDC, a);
    wr_byte({1'b1, ofs}, a);
    b_rstart;
    wr_byte(8'hDD, a); chk({tag, " read addr ack"}, 8'(a), 8'h01);
    rd_byte(1'b0, b);
    act_q.push_back(b);
    hq;
    chk("R10 sda released after nack", 8'(sda_oe), 8'h00);
    b_stop;
  endtask

  // monitor: pairs each byte the slave returned with the expected item
  initial begin
    forever begin
      wait (act_q.size() > 0);
      chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    repeat (5) @(posedge clk);
    #1 rst_ni = 1'b1;
    hq;
    check_outs("R7 reset");

    byte_write(7'd2, 8'hA5, "R2");
    check_outs("R2");

    // wrong address: no ack, following bytes ignored
    b_start;
    wr_byte(8'h50, a); chk("R1 foreign addr nack", 8'(a), 8'h00);
    wr_byte(8'h82, a);
    wr_byte(8'h11, a);
    b_stop;
    check_outs("R1");

    byte_read(7'd2, 8'hA5, "R3 reg2");
    byte_read(7'd0, 8'h07, "R3 reg0");

    // block write, count 3
    b_start;
    wr_byte(8'hDC, a); wr_byte(8'h00, a);
    wr_byte(8'h03, a); chk("R4 count ack", 8'(a), 8'h01);
    wr_byte(8'h13, a); wr_byte(8'h7E, a); wr_byte(8'hC3, a);
    chk("R4 data ack", 8'(a), 8'h01);
    b_stop;
    model[0] = 8'h13; model[1] = 8'h7E; model[2] = 8'hC3;
    check_outs("R4");

    // block write announcing 6 bytes, stopped after 2
    b_start;
    wr_byte(8'hDC, a); wr_byte(8'h00, a); wr_byte(8'h06, a);
    wr_byte(8'h55, a); wr_byte(8'h66, a);
    b_stop;
    model[0] = 8'h55; model[1] = 8'h66;
    check_outs("R5");

    // read-only and out-of-range offsets
    byte_write(7'd4, 8'hFF, "R8 ro");
    byte_write(7'd32, 8'h99, "R8 oob");
    check_outs("R8");
    byte_read(7'd32, 8'h00, "R8 oob read");
    byte_read(7'd4, 8'h08, "R8 ident read");

    // stop in the middle of a command byte
    b_start;
    wr_byte(8'hDC, a);
    for (int i = 0; i < 4; i++) begin
      m_low = 0; hq; scl = 1; hq; scl = 0;
    end
    hq;
    b_stop;
    chk("R9 sda released after stop", 8'(sda_oe), 8'h00);
    byte_write(7'd3, 8'h3C, "R9 recovery");
    byte_write(7'd5, 8'h5A, "R2 reg5");
    check_outs("R9");

    // block read: count then registers 0..5
    exp_q.push_back(8'h06); tag_q.push_back("R6 count");
    for (int i = 0; i < 6; i++) begin
      exp_q.push_back(model[i]); tag_q.push_back("R6 data");
    end
    b_start;
    wr_byte(8'hDC, a); wr_byte(8'h00, a);
    b_rstart;
    wr_byte(8'hDD, a); chk("R6 read addr ack", 8'(a), 8'h01);
    for (int i = 0; i < 7; i++) begin
      rd_byte(i != 6, b);
      act_q.push_back(b);
    end
    hq;
    chk("R10 released after block nack", 8'(sda_oe), 8'h00);
    b_stop;

    wait (act_q.size() == 0);
    hq;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule